// File: doc/BRIEF.md
# Three-Master Target Bus Arbiter

This block decides which of three masters owns a shared target bus: the main CPU, a debug master and a coprocessor. Each master presents a request, an address, a write flag and a flag marking an access to a special register region. The arbiter returns a registered one-hot grant, a stall line per master, a flag that reserves the external bus, and a mirror strobe that shows internal traffic on the external bus in emulation mode.

Ordinary priority is CPU, then debug master, then coprocessor. A coprocessor access to the special register region is the exception. It wins every free arbitration, it holds the CPU and debug master stalled for its whole duration, and it keeps the external bus reserved. An owner is never pre-empted, so a transfer is never split.

A small detector watches the CPU while it holds the bus. A CPU write that lands inside a protected coprocessor RAM window sets a sticky violation request. Software clears the request by writing 1 to it.

Top module: `tbus_arbiter`

## Requirements
- R1: At most one grant bit is high in any cycle. The bit positions are grant[0] for the CPU, grant[1] for the debug master and grant[2] for the coprocessor. A grant is registered and appears in the cycle after the request that wins.
- R2: On a free bus, a CPU request wins over both a debug request and an ordinary coprocessor request.
- R3: On a free bus, a debug request wins over an ordinary coprocessor request. A debug request held high while the CPU owns the bus is granted in the cycle after the CPU drops its request.
- R4: On a free bus, a coprocessor request with cop_spec high wins over every other request. While that access owns the bus, cpu_stall and dbg_stall are both high whatever their requests are.
- R5: ext_reserve is high exactly while a coprocessor special-region access owns the bus.
- R6: An owner keeps the grant for as long as its request stays high. No other request pre-empts it, not even a coprocessor special-region request.
- R7: ext_mirror is high when emul_mode is high and some master holds a grant, and is low otherwise.
- R8: Outside a special-region access, each stall output equals that master's request while the master is not granted.
- R9: A CPU write to an address in [PROT_LO, PROT_HI] (both ends inclusive) made while the CPU holds the grant sets viol_irq in the next cycle. A read, an address outside the window, or a write from a CPU that is not granted leaves viol_irq unchanged.
- R10: viol_irq stays set until viol_clr is 1 at a clock edge. If a new violation and a clear arrive in the same cycle, the flag stays set.
- R11: A synchronous active-low reset clears all grants, ext_reserve and viol_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| emul_mode | input | 1 | Emulation mode; shows internal accesses on the external bus |
| cpu_req | input | 1 | CPU request |
| cpu_wr | input | 1 | CPU write flag |
| cpu_addr | input | AW | CPU address |
| cpu_spec | input | 1 | CPU special-region decode (no priority effect) |
| dbg_req | input | 1 | Debug master request |
| dbg_wr | input | 1 | Debug master write flag |
| dbg_addr | input | AW | Debug master address |
| dbg_spec | input | 1 | Debug special-region decode (no priority effect) |
| cop_req | input | 1 | Coprocessor request |
| cop_wr | input | 1 | Coprocessor write flag |
| cop_addr | input | AW | Coprocessor address |
| cop_spec | input | 1 | Coprocessor access targets the special register region |
| viol_clr | input | 1 | Write-1-to-clear strobe for viol_irq |
| grant | output | 3 | One-hot grant: [0] CPU, [1] debug, [2] coprocessor |
| cpu_stall | output | 1 | CPU must wait |
| dbg_stall | output | 1 | Debug master must wait |
| cop_stall | output | 1 | Coprocessor must wait |
| ext_reserve | output | 1 | External bus reserved for a special-region access |
| ext_mirror | output | 1 | Current internal access is mirrored externally |
| viol_irq | output | 1 | Sticky CPU access-violation request |

## Verification
The hardest state to reach is a CPU write into the protected window while the CPU is not the owner. To reach it, the coprocessor first takes the bus with a special-region access while the CPU is idle. The CPU then raises a write into the window and stays stalled behind that access. The stimulus table also parks the debug master on the bus and then raises a coprocessor special request, to show that no pre-emption happens. A reset is applied in the middle of a special access while the violation flag is set.

// File: rtl/tbus_pkg.sv
// Package: shared owner encoding and master indices for the target bus arbiter.
// Assumes three masters in fixed order CPU, debug, coprocessor.
package tbus_pkg;
    localparam int NMAST = 3;
    localparam int M_CPU = 0;
    localparam int M_DBG = 1;
    localparam int M_COP = 2;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_CPU  = 2'd1,
        OWN_DBG  = 2'd2,
        OWN_COP  = 2'd3
    } owner_t;
endpackage

// File: rtl/tbus_pick.sv
// Module: next-owner selection. Purely combinational.
// Assumes req bit order CPU, debug, coprocessor. A live owner is never
// replaced. On a free bus a coprocessor special access goes first, then
// CPU, then debug, then an ordinary coprocessor access.
module tbus_pick
    import tbus_pkg::*;
(
    input  owner_t           cur,
    input  logic [NMAST-1:0] req,
    input  logic             cop_spec,
    output owner_t           nxt,
    output logic             special_start
);
    logic hold;

    // Decide whether the current owner keeps the bus.
    always_comb begin
        case (cur)
            OWN_CPU: hold = req[M_CPU];
            OWN_DBG: hold = req[M_DBG];
            OWN_COP: hold = req[M_COP];
            default: hold = 1'b0;
        endcase
    end

    // Choose the owner for the next cycle.
    always_comb begin
        special_start = 1'b0;
        nxt           = OWN_NONE;
        if (hold) begin
            nxt = cur;
        end else if (req[M_COP] && cop_spec) begin
            nxt           = OWN_COP;
            special_start = 1'b1;
        end else if (req[M_CPU]) begin
            nxt = OWN_CPU;
        end else if (req[M_DBG]) begin
            nxt = OWN_DBG;
        end else if (req[M_COP]) begin
            nxt = OWN_COP;
        end
    end
endmodule

// File: rtl/tbus_viol.sv
// Module: sticky detector for CPU writes into the protected coprocessor RAM window.
// Assumes the window bounds are inclusive and cpu_granted is the registered CPU grant.
module tbus_viol #(
    parameter int              AW      = 16,
    parameter logic [AW-1:0]   PROT_LO = 16'h2000,
    parameter logic [AW-1:0]   PROT_HI = 16'h27FF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_granted,
    input  logic          cpu_wr,
    input  logic [AW-1:0] cpu_addr,
    input  logic          clr,
    output logic          flag
);
    logic hit;

    // Flag a granted CPU write that falls inside the window.
    always_comb begin
        hit = cpu_granted && cpu_wr && (cpu_addr >= PROT_LO) && (cpu_addr <= PROT_HI);
    end

    // Hold the flag until cleared; a new hit beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= hit | (flag & ~clr);
    end
endmodule

// File: rtl/tbus_arbiter.sv
// Module: fixed-priority arbiter for one target bus shared by CPU, debug master
// and coprocessor. Grants are registered and one-hot. A coprocessor special-region
// access stalls the CPU and debug master and reserves the external bus.
// Assumes masters hold their request high for the whole of an access.
module tbus_arbiter
    import tbus_pkg::*;
#(
    parameter int            AW      = 16,
    parameter logic [AW-1:0] PROT_LO = 16'h2000,
    parameter logic [AW-1:0] PROT_HI = 16'h27FF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             emul_mode,
    input  logic             cpu_req,
    input  logic             cpu_wr,
    input  logic [AW-1:0]    cpu_addr,
    input  logic             cpu_spec,
    input  logic             dbg_req,
    input  logic             dbg_wr,
    input  logic [AW-1:0]    dbg_addr,
    input  logic             dbg_spec,
    input  logic             cop_req,
    input  logic             cop_wr,
    input  logic [AW-1:0]    cop_addr,
    input  logic             cop_spec,
    input  logic             viol_clr,
    output logic [NMAST-1:0] grant,
    output logic             cpu_stall,
    output logic             dbg_stall,
    output logic             cop_stall,
    output logic             ext_reserve,
    output logic             ext_mirror,
    output logic             viol_irq
);
    localparam int OWN_W = $bits(owner_t);

    owner_t           owner_q;
    owner_t           owner_d;
    logic             special_q;
    logic             special_start;
    logic             special_d;
    logic [NMAST-1:0] req;

    // Unused decode inputs are kept for a uniform master interface.
    logic unused_ok;
    assign unused_ok = ^{cpu_spec, dbg_wr, dbg_addr, dbg_spec, cop_wr, cop_addr};

    // Gather requests in master index order.
    always_comb begin
        req        = '0;
        req[M_CPU] = cpu_req;
        req[M_DBG] = dbg_req;
        req[M_COP] = cop_req;
    end

    tbus_pick u_pick (
        .cur           (owner_q),
        .req           (req),
        .cop_spec      (cop_spec),
        .nxt           (owner_d),
        .special_start (special_start)
    );

    // Keep the special flag while the coprocessor holds its access.
    always_comb begin
        special_d = special_start | (special_q && (owner_q == OWN_COP) && cop_req);
    end

    // Register the owner and the special-access flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q   <= OWN_NONE;
            special_q <= 1'b0;
        end else begin
            owner_q   <= owner_d;
            special_q <= special_d;
        end
    end

    // Decode the owner into one grant line per master.
    for (genvar gi = 0; gi < NMAST; gi++) begin : g_grant
        assign grant[gi] = (owner_q == owner_t'(OWN_W'(gi + 1)));
    end

    // Stall a waiting master; a special access holds off CPU and debug.
    always_comb begin
        cpu_stall = (cpu_req & ~grant[M_CPU]) | special_q;
        dbg_stall = (dbg_req & ~grant[M_DBG]) | special_q;
        cop_stall = cop_req & ~grant[M_COP];
    end

    // Drive the external bus reserve and the emulation mirror.
    always_comb begin
        ext_reserve = special_q;
        ext_mirror  = emul_mode & (|grant);
    end

    tbus_viol #(
        .AW      (AW),
        .PROT_LO (PROT_LO),
        .PROT_HI (PROT_HI)
    ) u_viol (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_granted (grant[M_CPU]),
        .cpu_wr      (cpu_wr),
        .cpu_addr    (cpu_addr),
        .clr         (viol_clr),
        .flag        (viol_irq)
    );
endmodule

// File: rtl/tbus_arbiter_chk.sv
// Module: property checker bound to tbus_arbiter. Observes ports only.
module tbus_arbiter_chk #(
    parameter int            AW      = 16,
    parameter logic [AW-1:0] PROT_LO = 16'h2000,
    parameter logic [AW-1:0] PROT_HI = 16'h27FF
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_req,
    input logic          cpu_wr,
    input logic [AW-1:0] cpu_addr,
    input logic          dbg_req,
    input logic          viol_clr,
    input logic [2:0]    grant,
    input logic          cpu_stall,
    input logic          dbg_stall,
    input logic          ext_reserve,
    input logic          viol_irq
);
    logic in_win;
    assign in_win = (cpu_addr >= PROT_LO) && (cpu_addr <= PROT_HI);

    // R1
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R2
    cop_low_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[2] && !$past(grant[2]) && !ext_reserve) |-> (!$past(cpu_req) && !$past(dbg_req)));

    // R4
    special_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_reserve |-> (cpu_stall && dbg_stall && grant[2]));

    // R6
    cpu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(grant[0]) && $past(cpu_req)) |-> grant[0]);

    // R9
    viol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(grant[0] && cpu_wr && in_win) |-> viol_irq);

    // R10
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_irq && !viol_clr) |=> viol_irq);
endmodule

bind tbus_arbiter tbus_arbiter_chk #(
    .AW      (AW),
    .PROT_LO (PROT_LO),
    .PROT_HI (PROT_HI)
) u_chk (.*);

// File: tb/tbus_arbiter_test.sv
`timescale 1ns/1ps
module tbus_arbiter_test;
    localparam int            AW = 16;
    localparam logic [AW-1:0] LO = 16'h2000;
    localparam logic [AW-1:0] HI = 16'h27FF;
    localparam int            NV = 11;

    // Vector: {cpu_req,dbg_req,cop_req,cop_spec,emul, exp_grant[2:0], exp_res,exp_mir,exp_cstall,exp_dstall}
    localparam logic [11:0] TBL [NV] = '{
        {5'b00000, 3'b000, 4'b0000},   // idle
        {5'b11100, 3'b001, 4'b0001},   // R2 CPU wins
        {5'b11100, 3'b001, 4'b0001},   // R6 CPU holds
        {5'b01100, 3'b010, 4'b0000},   // R3 pending debug gets it
        {5'b01110, 3'b010, 4'b0000},   // R6 no pre-emption by special
        {5'b10110, 3'b100, 4'b1011},   // R4 special beats CPU
        {5'b10111, 3'b100, 4'b1111},   // R5 R7 reserve and mirror
        {5'b11001, 3'b001, 4'b0101},   // R7 mirror on CPU access
        {5'b00100, 3'b100, 4'b0000},   // ordinary coprocessor
        {5'b10100, 3'b100, 4'b0010},   // R6 R8 CPU waits
        {5'b00000, 3'b000, 4'b0000}    // release
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic emul_mode = 1'b0;
    logic cpu_req = 1'b0, cpu_wr = 1'b0, cpu_spec = 1'b0;
    logic dbg_req = 1'b0, dbg_wr = 1'b0, dbg_spec = 1'b0;
    logic cop_req = 1'b0, cop_wr = 1'b0, cop_spec = 1'b0;
    logic [AW-1:0] cpu_addr = '0, dbg_addr = '0, cop_addr = '0;
    logic viol_clr = 1'b0;
    logic [2:0] grant;
    logic cpu_stall, dbg_stall, cop_stall, ext_reserve, ext_mirror, viol_irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tbus_arbiter #(.AW(AW), .PROT_LO(LO), .PROT_HI(HI)) uut (
        .clk(clk), .rst_n(rst_n), .emul_mode(emul_mode),
        .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_spec(cpu_spec),
        .dbg_req(dbg_req), .dbg_wr(dbg_wr), .dbg_addr(dbg_addr), .dbg_spec(dbg_spec),
        .cop_req(cop_req), .cop_wr(cop_wr), .cop_addr(cop_addr), .cop_spec(cop_spec),
        .viol_clr(viol_clr), .grant(grant),
        .cpu_stall(cpu_stall), .dbg_stall(dbg_stall), .cop_stall(cop_stall),
        .ext_reserve(ext_reserve), .ext_mirror(ext_mirror), .viol_irq(viol_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive nothing new; let one clock edge pass, then sample away from it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tick(); tick();
        // R11 reset state
        chk("R11 grant after reset", 32'(grant), 0);
        chk("R11 reserve after reset", 32'(ext_reserve), 0);
        chk("R11 viol after reset", 32'(viol_irq), 0);
        @(negedge clk) rst_n = 1'b1;

        // Table walk
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            {cpu_req, dbg_req, cop_req, cop_spec, emul_mode} = TBL[k][11:7];
            tick();
            chk($sformatf("R1 R2 R3 R4 R6 grant v%0d", k), 32'(grant), 32'(TBL[k][6:4]));
            chk($sformatf("R5 reserve v%0d", k), 32'(ext_reserve), 32'(TBL[k][3]));
            chk($sformatf("R7 mirror v%0d", k), 32'(ext_mirror), 32'(TBL[k][2]));
            chk($sformatf("R8 R4 cpu_stall v%0d", k), 32'(cpu_stall), 32'(TBL[k][1]));
            chk($sformatf("R8 R4 dbg_stall v%0d", k), 32'(dbg_stall), 32'(TBL[k][0]));
        end
        @(negedge clk) {cop_spec, emul_mode} = 2'b00;

        // R9 write at the low edge of the window
        @(negedge clk) begin cpu_req = 1; cpu_wr = 1; cpu_addr = LO; end
        tick();
        chk("R9 cpu granted", 32'(grant), 1);
        chk("R9 flag not yet", 32'(viol_irq), 0);
        tick();
        chk("R9 violation at low edge", 32'(viol_irq), 1);
        // R10 sticky through reads
        @(negedge clk) begin cpu_wr = 0; end
        tick(); tick();
        chk("R10 sticky", 32'(viol_irq), 1);
        @(negedge clk) viol_clr = 1;
        tick();
        chk("R10 cleared", 32'(viol_irq), 0);
        // R9 just above the window and a read inside it
        @(negedge clk) begin viol_clr = 0; cpu_wr = 1; cpu_addr = HI + 1'b1; end
        tick(); tick();
        chk("R9 outside window", 32'(viol_irq), 0);
        @(negedge clk) begin cpu_wr = 0; cpu_addr = HI; end
        tick(); tick();
        chk("R9 read in window", 32'(viol_irq), 0);
        // R10 set and clear together
        @(negedge clk) begin cpu_wr = 1; cpu_addr = HI; viol_clr = 1; end
        tick();
        chk("R10 set beats clear", 32'(viol_irq), 1);
        @(negedge clk) begin cpu_wr = 0; end
        tick();
        chk("R10 clear after", 32'(viol_irq), 0);
        @(negedge clk) begin viol_clr = 0; cpu_req = 0; end
        tick();

        // R9 ungranted CPU write during a special access
        @(negedge clk) begin cop_req = 1; cop_spec = 1; end
        tick();
        chk("R4 special granted", 32'(grant), 4);
        @(negedge clk) begin cpu_req = 1; cpu_wr = 1; cpu_addr = LO + 16'h10; end
        tick(); tick();
        chk("R9 ungranted write ignored", 32'(viol_irq), 0);
        chk("R4 cpu stalled", 32'(cpu_stall), 1);
        chk("R5 reserve held", 32'(ext_reserve), 1);
        // Release, let CPU write to set the flag, then special again
        @(negedge clk) begin cop_req = 0; end
        tick(); tick();
        chk("R9 granted write after release", 32'(viol_irq), 1);
        @(negedge clk) begin cpu_req = 0; cpu_wr = 0; cop_req = 1; end
        tick();
        chk("R5 reserve again", 32'(ext_reserve), 1);

        // R11 reset in the middle of a special access
        @(negedge clk) rst_n = 0;
        tick();
        chk("R11 grant cleared", 32'(grant), 0);
        chk("R11 reserve cleared", 32'(ext_reserve), 0);
        chk("R11 viol cleared", 32'(viol_irq), 0);
        @(negedge clk) begin rst_n = 1; cop_req = 0; cop_spec = 0; end
        tick();
        chk("R1 idle after reset", 32'(grant), 0);

        finish_run();
    end
endmodule